// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This block merges four interrupt sources into one request line to a CPU: a raster source and three sound-channel requests. The raster source fires either from a legacy per-frame pulse or, when a line compare register holds a nonzero value, at the end of the matching scan line. Software can rewrite the compare value during a frame to get several raster interrupts per frame.

Each source has a pending flag, and the flags are served in a fixed priority order. When the CPU runs an acknowledge cycle, the block latches an 8-bit vector. The upper five bits of that vector come from a programmable vector register, and two bits name the source being served. Bit 0 of the vector register picks how sound-channel flags are cleared. At 0, the acknowledge clears the flag of the channel it served. At 1, software has to clear the flag by writing a one to the matching status bit. A status byte reports which channel flags are pending and whether the most recent acknowledge served the raster source.

Top module: `irq_vec_unit`

## Requirements
- R1: The vector byte is {vector register bits 7..3, 2-bit source code, 0}. It is latched on an acknowledge cycle in which at least one flag is pending, and it is visible from the following cycle.
- R2: Source codes are raster=11, channel 2=00, channel 1=01, channel 0=10. The served source is the highest-priority pending flag, in the order raster, channel 2, channel 1, channel 0.
- R3: `irq` is 1 exactly when at least one pending flag is set.
- R4: Every acknowledge cycle clears the raster flag. A register write with `wr_sel`=3 (mode) and data bit 4 set also clears it. A mode write with bit 4 clear has no effect.
- R5: With vector register bit 0 at 0, an acknowledge also clears the flag of the channel it served, and only that flag.
- R6: With vector register bit 0 at 1, an acknowledge leaves channel flags alone. A write with `wr_sel`=2 (status) clears channel i when data bit 6-i is 1. Zero bits have no effect.
- R7: `stat` bit 7 is 1 when the last vector-producing acknowledge served the raster source. Bits 6, 5 and 4 show the pending flags of channels 0, 1 and 2. Bits 3..0 read 0.
- R8: After reset the compare register is 0, vector register bit 0 is 1 and bits 7..3 are 0. All flags are clear, so `irq`=0, `stat`=0 and `vec`=0.
- R9: While the compare register (`wr_sel`=1) is 0, `legacy_pulse` sets the raster flag. While it is nonzero, only `line_end` with `line_num` equal to the compare value sets the flag, and `legacy_pulse` is ignored.
- R10: A request that arrives in the same cycle as a clear of the same flag leaves the flag set.
- R11: An acknowledge with no flag pending leaves `vec` and `stat` bit 7 unchanged.
- R12: Vector register writes use `wr_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_num | input | LINE_W | Current scan line number |
| line_end | input | 1 | One-cycle end-of-line strobe |
| legacy_pulse | input | 1 | Legacy raster interrupt pulse |
| ch_req | input | 3 | Sound-channel interrupt requests, bit i = channel i |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 vector, 1 compare, 2 status, 3 mode |
| wr_data | input | 8 | Write data |
| ack | input | 1 | Interrupt acknowledge cycle strobe |
| irq | output | 1 | Interrupt request line |
| vec | output | 8 | Vector byte latched on acknowledge |
| stat | output | 8 | Status bits |

## Verification
The bench builds the block with the default 8-bit line number, so every compare value from 1 to 255 can be matched directly. A vector table puts all four sources into contention, with automatic clearing on, and walks the priority chain one acknowledge at a time. Directed steps then cover the reset-time manual clear mode, a request that collides with a clear, an acknowledge with nothing pending, and the mode-register clear. They also cover a compare register rewritten within a frame and the return to the legacy pulse.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CH_N = 3;

  typedef enum logic [1:0] {
    SEL_VEC  = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_MODE = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    SRC_CH2 = 2'b00,
    SRC_CH1 = 2'b01,
    SRC_CH0 = 2'b10,
    SRC_RAS = 2'b11
  } src_code_e;
endpackage

// File: rtl/irq_raster_trig.sv
module irq_raster_trig #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic              line_end,
  input  logic              legacy_pulse,
  input  logic              cmp_we,
  input  logic [7:0]        cmp_wd,
  output logic              ras_set
);
  logic [7:0] cmp_q, cmp_d;
  logic       cmp_zero;

  always_comb begin
    cmp_d = cmp_q;
    if (cmp_we) cmp_d = cmp_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_d;
  end

  assign cmp_zero = (cmp_q == 8'd0);

  always_comb begin
    if (cmp_zero) ras_set = legacy_pulse;
    else          ras_set = line_end && (line_num == LINE_W'(cmp_q));
  end

  AST_LEGACY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_zero && !line_end) |-> !ras_set) else $error("legacy trigger leaked"); // R9
endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras_set,
  input  logic [CH_N-1:0] ch_set,
  input  logic            ack,
  input  logic            auto_clr,
  input  logic            st_wr,
  input  logic [CH_N-1:0] st_clr,
  input  logic            mode_clr,
  output logic            ras_p,
  output logic [CH_N-1:0] ch_p,
  output logic [1:0]      code,
  output logic            any
);
  logic            ras_d;
  logic [CH_N-1:0] ch_d;
  logic [CH_N-1:0] served;

  always_comb begin
    code   = SRC_CH0;
    served = '0;
    if (ras_p) begin
      code = SRC_RAS;
    end else if (ch_p[2]) begin
      code = SRC_CH2;  served = 3'b100;
    end else if (ch_p[1]) begin
      code = SRC_CH1;  served = 3'b010;
    end else if (ch_p[0]) begin
      code = SRC_CH0;  served = 3'b001;
    end
  end

  assign any   = ras_p | (|ch_p);
  assign ras_d = ras_set | (ras_p & ~(ack | mode_clr));

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    assign ch_d[i] = ch_set[i] |
                     (ch_p[i] & ~(st_wr & st_clr[i]) & ~(ack & auto_clr & served[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p <= 1'b0;
      ch_p  <= '0;
    end else begin
      ras_p <= ras_d;
      ch_p  <= ch_d;
    end
  end

  AST_RAS_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ras_set) |=> !ras_p) else $error("raster flag survived ack"); // R4
  AST_MANUAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !auto_clr && !st_wr) |=> ((ch_p & $past(ch_p)) == $past(ch_p)))
    else $error("channel flag lost in manual mode"); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_set != '0) |=> ((ch_p & $past(ch_set)) == $past(ch_set)))
    else $error("request lost"); // R10
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irq_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic              line_end,
  input  logic              legacy_pulse,
  input  logic [2:0]        ch_req,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              ack,
  output logic              irq,
  output logic [7:0]        vec,
  output logic [7:0]        stat
);
  logic       rst_s1, rst_q;
  logic [4:0] vhi_q, vhi_d;
  logic       vauto_n_q, vauto_n_d;
  logic [7:0] vec_q, vec_d;
  logic       last_ras_q, last_ras_d;
  logic       ras_set, ras_p, any;
  logic [CH_N-1:0] ch_p, st_clr;
  logic [1:0] code;
  logic       we_vec, we_cmp, we_stat, we_mode, take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  assign we_vec  = wr_en && (wr_sel == SEL_VEC);
  assign we_cmp  = wr_en && (wr_sel == SEL_CMP);
  assign we_stat = wr_en && (wr_sel == SEL_STAT);
  assign we_mode = wr_en && (wr_sel == SEL_MODE) && wr_data[4];
  assign st_clr  = {wr_data[4], wr_data[5], wr_data[6]};
  assign take    = ack && any;

  irq_raster_trig #(.LINE_W(LINE_W)) u_trig (
    .clk(clk), .rst_n(rst_q), .line_num(line_num), .line_end(line_end),
    .legacy_pulse(legacy_pulse), .cmp_we(we_cmp), .cmp_wd(wr_data),
    .ras_set(ras_set)
  );

  irq_pend_arb u_pend (
    .clk(clk), .rst_n(rst_q), .ras_set(ras_set), .ch_set(ch_req), .ack(ack),
    .auto_clr(!vauto_n_q), .st_wr(we_stat), .st_clr(st_clr), .mode_clr(we_mode),
    .ras_p(ras_p), .ch_p(ch_p), .code(code), .any(any)
  );

  always_comb begin
    vhi_d      = vhi_q;
    vauto_n_d  = vauto_n_q;
    vec_d      = vec_q;
    last_ras_d = last_ras_q;
    if (we_vec) begin
      vhi_d     = wr_data[7:3];
      vauto_n_d = wr_data[0];
    end
    if (take) begin
      vec_d      = {vhi_q, code, 1'b0};
      last_ras_d = ras_p;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vhi_q      <= '0;
      vauto_n_q  <= 1'b1;
      vec_q      <= '0;
      last_ras_q <= 1'b0;
    end else begin
      vhi_q      <= vhi_d;
      vauto_n_q  <= vauto_n_d;
      vec_q      <= vec_d;
      last_ras_q <= last_ras_d;
    end
  end

  assign irq  = any;
  assign vec  = vec_q;
  assign stat = {last_ras_q, ch_p[0], ch_p[1], ch_p[2], 4'b0000};

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    !irq |-> (stat[6:4] == 3'b000)) else $error("flag pending with irq low"); // R3
  AST_RAS_FIRST: assert property (@(posedge clk) disable iff (!rst_q)
    (ack && ras_p) |=> (vec[2:1] == 2'b11 && stat[7])) else $error("raster not served"); // R2
  AST_EMPTY_ACK: assert property (@(posedge clk) disable iff (!rst_q)
    (ack && !irq) |=> ($stable(vec) && $stable(stat[7]))) else $error("empty ack changed vector"); // R11
endmodule

// File: tb/sim_irq_vec_unit.sv
module sim_irq_vec_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] line_num;
  logic       line_end, legacy_pulse, wr_en, ack;
  logic [2:0] ch_req;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       irq;
  logic [7:0] vec, stat;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_vec_unit #(.LINE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .line_end(line_end),
    .legacy_pulse(legacy_pulse), .ch_req(ch_req), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack(ack), .irq(irq), .vec(vec), .stat(stat)
  );

  // {legacy, ch_req[2:0], ack, exp_irq, exp_vec, exp_stat}; vector reg = A8h (auto clear)
  localparam logic [21:0] TBL [8] = '{
    {1'b1, 3'b111, 1'b1, 1'b1, 8'hAE, 8'hF0},
    {1'b0, 3'b000, 1'b1, 1'b1, 8'hA8, 8'h60},
    {1'b0, 3'b000, 1'b1, 1'b1, 8'hAA, 8'h40},
    {1'b0, 3'b100, 1'b1, 1'b1, 8'hA8, 8'h40},
    {1'b0, 3'b000, 1'b1, 1'b0, 8'hAC, 8'h00},
    {1'b1, 3'b000, 1'b1, 1'b0, 8'hAE, 8'h80},
    {1'b0, 3'b001, 1'b0, 1'b1, 8'hAE, 8'hC0},
    {1'b0, 3'b000, 1'b1, 1'b0, 8'hAC, 8'h00}
  };

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual {irq,vec,stat}=%h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    line_end = 0; legacy_pulse = 0; ch_req = 0; wr_en = 0; ack = 0; wr_data = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; step();
  endtask

  task automatic do_ack();
    ack = 1; step();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; line_num = 0; wr_sel = 0; idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) step();
    chk("R8 reset", {irq, vec, stat}, {1'b0, 8'h00, 8'h00});

    // R6 manual clear after reset (vector reg bit0 = 1), R1 vector with zero upper bits
    ch_req = 3'b010; step();
    do_ack();
    chk("R6 ack keeps flag, R1 vector", {irq, vec, stat}, {1'b1, 8'h02, 8'h20});
    wr(2'd2, 8'h00);
    chk("R6 zero bits ignored", {irq, vec, stat}, {1'b1, 8'h02, 8'h20});
    wr(2'd2, 8'h20);
    chk("R6 write-one clears", {irq, vec, stat}, {1'b0, 8'h02, 8'h00});

    // R10 request collides with clear
    ch_req = 3'b001; wr_en = 1; wr_sel = 2'd2; wr_data = 8'h40; step();
    chk("R10 set wins", {irq, vec, stat}, {1'b1, 8'h02, 8'h40});
    wr(2'd2, 8'h40);

    // R12 program vector register, auto clear on
    wr(2'd0, 8'hA8);
    for (int i = 0; i < 8; i++) begin
      legacy_pulse = TBL[i][21]; ch_req = TBL[i][20:18]; step();
      ack = TBL[i][17]; step();
      chk($sformatf("R2 R5 R7 R3 table row %0d", i), {irq, vec, stat}, TBL[i][16:0]);
    end

    // R11 empty acknowledge after a raster service
    legacy_pulse = 1; step();
    do_ack();
    chk("R7 raster served", {irq, vec, stat}, {1'b0, 8'hAE, 8'h80});
    do_ack();
    chk("R11 empty ack", {irq, vec, stat}, {1'b0, 8'hAE, 8'h80});

    // R4 mode register clear
    legacy_pulse = 1; step();
    wr(2'd3, 8'h0F);
    chk("R4 mode write without bit 4", {irq, vec, stat}, {1'b1, 8'hAE, 8'h80});
    wr(2'd3, 8'h10);
    chk("R4 mode write bit 4 clears", {irq, vec, stat}, {1'b0, 8'hAE, 8'h80});

    // R9 line compare
    wr(2'd1, 8'd5);
    legacy_pulse = 1; step();
    chk("R9 legacy ignored", {irq, vec, stat}, {1'b0, 8'hAE, 8'h80});
    line_num = 8'd4; line_end = 1; step();
    chk("R9 other line", {irq, vec, stat}, {1'b0, 8'hAE, 8'h80});
    line_num = 8'd5; step();
    chk("R9 no strobe", {irq, vec, stat}, {1'b0, 8'hAE, 8'h80});
    line_end = 1; step();
    chk("R9 match fires", {irq, vec, stat}, {1'b1, 8'hAE, 8'h80});
    do_ack();
    wr(2'd1, 8'd9);
    line_num = 8'd9; line_end = 1; step();
    chk("R9 rewritten compare fires again", {irq, vec, stat}, {1'b1, 8'hAE, 8'h80});
    do_ack();
    wr(2'd1, 8'd0);
    legacy_pulse = 1; step();
    chk("R9 zero compare uses legacy", {irq, vec, stat}, {1'b1, 8'hAE, 8'h80});
    do_ack();
    chk("R4 ack clears raster", {irq, vec, stat}, {1'b0, 8'hAE, 8'h80});

    finish_run();
  end
endmodule